// File: doc/BRIEF.md
# Burst-Capable Word Read Port

This block is the read side of a 32-bit-wide nonvolatile memory device. It serves two kinds of read. In asynchronous mode the data bus follows the address pins while the chip is selected and the output is enabled. In synchronous mode a start address is captured on a clock edge. An internal counter then steps through consecutive words, one per clock, while the host holds the advance pin active. The host can pause a running burst to free the shared bus, continue it later from the same word, or end it with chip select or the reset/power-down pin.

A two-field configuration register chooses the read mode and controls standby. It is written through a single-cycle write port. The memory contents come from a computed array model, so every word is known without preloading. The bus is presented as a data value plus a drive-enable for the pad. All mode pins are active low.

Top module: `flash_burst_rd`

## Requirements
- R1: While `rst_ni` is low, `data_oe_o` is 0 and `data_o` is 0. With `ce_ni` high after reset, `standby_o` is 1.
- R2: After reset the effective mode is asynchronous. With `ce_ni` and `oe_ni` both low, `data_oe_o` is 1 and `data_o` is the array word at `addr_i` with no clock needed. The array word at address a is {a ^ 16'hC35A, a}, with the upper half in bits 31:16.
- R3: A rising clock edge with `ce_ni` and `adv_ni` both low captures `addr_i` into the burst counter. If configuration bit 15 is 0 at that edge, a synchronous burst starts, and `data_o` shows the word at the captured address from that edge on whenever `oe_ni` is low.
- R4: During a synchronous burst, each rising edge with `ce_ni`, `oe_ni` and `burst_ni` low and `adv_ni` high moves the counter up by one and puts the next word on the bus. During the burst, `addr_i` has no effect on `data_o`.
- R5: With `oe_ni` high, the counter holds, and with `oe_ni` and `burst_ni` both high the bus is not driven. When `oe_ni` returns low, the bus again shows the word at the held address.
- R6: The counter wraps from the last address (16'hFFFF) to 0.
- R7: `ce_ni` high stops driving at once and ends the burst. Lowering `ce_ni` and `oe_ni` again does not drive the bus, and advance edges do not drive it either, until a new address capture.
- R8: `rst_ni` low ends a burst at once and restores configuration bit 15 to 1 and bit 14 to 0. After release, reads are asynchronous without any capture.
- R9: Configuration bit 14 set to 1 keeps `standby_o` at 0 while `ce_ni` is high. With bit 14 at 0, `standby_o` equals `ce_ni`.
- R10: A configuration write changes the effective read mode only at the next address capture. A burst in progress keeps stepping after bit 15 is written to 1, and reads stay asynchronous after bit 15 is written to 0 until a capture.
- R11: Whenever `data_oe_o` is 0, `data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Burst clock |
| rst_ni | input | 1 | Asynchronous reset / power-down, active low |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| adv_ni | input | 1 | Address capture strobe, active low |
| burst_ni | input | 1 | Burst advance, active low |
| addr_i | input | 16 | Word address |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 16 | Configuration write data (bit 15 read mode, bit 14 standby disable) |
| data_o | output | 32 | Read data |
| data_oe_o | output | 1 | Pad drive enable for data_o |
| standby_o | output | 1 | Device in standby |

## Verification
A wrong counter value shows up as a wrong data word on the first enabled cycle after the faulty edge. The bench reads every word after each step, after a suspend and after a wrap, so an extra or missing increment is caught within one clock. A stale burst-active flag or an effective-mode flag updated at the wrong time shows up as drive on a bus that should float, or as data that follows `addr_i` when it should follow the counter. The abort, reset and mid-burst configuration scenarios each sample that state at the ports before the next capture could hide it.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  localparam int RD_ASYNC_BIT = 15;
  localparam int STBY_DIS_BIT = 14;

  typedef struct packed {
    logic rd_async;
    logic stby_dis;
  } rd_cfg_t;

  localparam rd_cfg_t CFG_RST = '{rd_async: 1'b1, stby_dis: 1'b0};

  typedef enum logic {
    MODE_ASYNC = 1'b0,
    MODE_SYNC  = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/flash_rd_cfg.sv
module flash_rd_cfg
  import flash_rd_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [CW-1:0] wdata_i,
  output rd_cfg_t       cfg_o
);
  rd_cfg_t cfg_q;
  logic    unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
    end else if (we_i) begin
      cfg_q <= '{rd_async: wdata_i[RD_ASYNC_BIT], stby_dis: wdata_i[STBY_DIS_BIT]};
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/flash_burst_ctr.sv
module flash_burst_ctr #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] load_addr_i,
  output logic [AW-1:0] ctr_o
);
  logic [AW-1:0] ctr_q;

  // load wins over step; natural overflow gives the wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctr_q <= '0;
    end else if (load_i) begin
      ctr_q <= load_addr_i;
    end else if (step_i) begin
      ctr_q <= ctr_q + 1'b1;
    end
  end

  assign ctr_o = ctr_q;
endmodule

// File: rtl/flash_array_model.sv
module flash_array_model #(
  parameter int          AW   = 16,
  parameter int          DW   = 32,
  parameter logic [15:0] SEED = 16'hC35A
) (
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] word_o
);
  localparam int LANES = DW / 16;

  logic [15:0] a16;
  assign a16 = 16'(addr_i);

  // lane k = address ^ (SEED * k)
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [15:0] LANE_KEY = 16'(SEED * k);
    assign word_o[k*16 +: 16] = a16 ^ LANE_KEY;
  end
endmodule

// File: rtl/flash_burst_rd.sv
module flash_burst_rd
  import flash_rd_pkg::*;
#(
  parameter int          AW   = 16,
  parameter int          DW   = 32,
  parameter int          CW   = 16,
  parameter logic [15:0] SEED = 16'hC35A
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          adv_ni,
  input  logic          burst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          cfg_we_i,
  input  logic [CW-1:0] cfg_wdata_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          standby_o
);
  rd_cfg_t       cfg;
  rd_mode_e      mode_q;
  logic          burst_act_q;
  logic          latch_ev;
  logic          step_ev;
  logic          drive;
  logic [AW-1:0] ctr_q;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] word;

  flash_rd_cfg #(.CW(CW)) i_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .wdata_i(cfg_wdata_i),
    .cfg_o  (cfg)
  );

  assign latch_ev = !ce_ni && !adv_ni;
  assign step_ev  = burst_act_q && (mode_q == MODE_SYNC) && !ce_ni && adv_ni
                    && !oe_ni && !burst_ni;

  // mode is sampled from the config only at address capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= MODE_ASYNC;
      burst_act_q <= 1'b0;
    end else if (ce_ni) begin
      burst_act_q <= 1'b0;
    end else if (latch_ev) begin
      mode_q      <= cfg.rd_async ? MODE_ASYNC : MODE_SYNC;
      burst_act_q <= !cfg.rd_async;
    end
  end

  flash_burst_ctr #(.AW(AW)) i_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (latch_ev),
    .step_i     (step_ev),
    .load_addr_i(addr_i),
    .ctr_o      (ctr_q)
  );

  assign rd_addr = (mode_q == MODE_SYNC) ? ctr_q : addr_i;

  flash_array_model #(.AW(AW), .DW(DW), .SEED(SEED)) i_array (
    .addr_i(rd_addr),
    .word_o(word)
  );

  always_comb begin
    drive = rst_ni && !ce_ni && !oe_ni;
    if (mode_q == MODE_SYNC) drive = drive && burst_act_q;
  end

  assign data_oe_o = drive;
  assign data_o    = drive ? word : '0;
  assign standby_o = ce_ni && !cfg.stby_dis;
endmodule

// File: rtl/flash_burst_rd_chk.sv
module flash_burst_rd_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_ni,
  input logic          oe_ni,
  input logic          adv_ni,
  input logic          burst_ni,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] data_o,
  input logic          data_oe_o,
  input logic [AW-1:0] ctr_q,
  input logic          burst_act_q,
  input logic          mode_q
);
  // R3 capture loads the counter
  a_r3_latch_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !adv_ni) |=> (ctr_q == $past(addr_i)));

  // R4 one step per enabled edge
  a_r4_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_act_q && mode_q && !ce_ni && adv_ni && !oe_ni && !burst_ni)
    |=> (ctr_q == AW'($past(ctr_q) + 1'b1)));

  // R5 output disabled freezes the counter
  a_r5_suspend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && adv_ni && oe_ni) |=> $stable(ctr_q));

  // R7 deselect floats the bus
  a_r7_ce_floats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> !data_oe_o);

  // R7 deselect ends the burst
  a_r7_ce_ends_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> !burst_act_q);

  // R11 idle bus reads zero
  a_r11_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0));
endmodule

bind flash_burst_rd flash_burst_rd_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_ni      (ce_ni),
  .oe_ni      (oe_ni),
  .adv_ni     (adv_ni),
  .burst_ni   (burst_ni),
  .addr_i     (addr_i),
  .data_o     (data_o),
  .data_oe_o  (data_oe_o),
  .ctr_q      (ctr_q),
  .burst_act_q(burst_act_q),
  .mode_q     (mode_q)
);

// File: tb/test_flash_burst_rd.sv
module test_flash_burst_rd;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_ni = 1'b1;
  logic        oe_ni = 1'b1;
  logic        adv_ni = 1'b1;
  logic        burst_ni = 1'b1;
  logic [15:0] addr_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic [31:0] data_o;
  logic        data_oe_o;
  logic        standby_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  flash_burst_rd i_flash_burst_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_ni      (ce_ni),
    .oe_ni      (oe_ni),
    .adv_ni     (adv_ni),
    .burst_ni   (burst_ni),
    .addr_i     (addr_i),
    .cfg_we_i   (cfg_we_i),
    .cfg_wdata_i(cfg_wdata_i),
    .data_o     (data_o),
    .data_oe_o  (data_oe_o),
    .standby_o  (standby_o)
  );

  function automatic logic [31:0] word_at(input logic [15:0] a);
    return {a ^ 16'hC35A, a};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic cfg_write(input logic [15:0] v);
    cfg_we_i = 1'b1;
    cfg_wdata_i = v;
    tick();
    cfg_we_i = 1'b0;
  endtask

  task automatic capture(input logic [15:0] a);
    adv_ni = 1'b0;
    addr_i = a;
    tick();
    adv_ni = 1'b1;
  endtask

  task automatic t_reset();
    settle();
    chk("R1", "oe in reset", 32'(data_oe_o), 32'd0);
    chk("R1", "data in reset", data_o, 32'd0);
    ce_ni = 1'b0; oe_ni = 1'b0; settle();
    chk("R1", "oe in reset selected", 32'(data_oe_o), 32'd0);
    ce_ni = 1'b1; oe_ni = 1'b1;
    tick(); rst_ni = 1'b1; tick();
    chk("R1", "standby after reset", 32'(standby_o), 32'd1);
  endtask

  task automatic t_async();
    ce_ni = 1'b0; oe_ni = 1'b0; addr_i = 16'h0005; settle();
    chk("R2", "async oe", 32'(data_oe_o), 32'd1);
    chk("R2", "async word", data_o, word_at(16'h0005));
    addr_i = 16'h1234; settle();
    chk("R2", "async follows addr", data_o, word_at(16'h1234));
    oe_ni = 1'b1; settle();
    chk("R11", "oe high zero bus", data_o, 32'd0);
  endtask

  task automatic t_burst();
    cfg_write(16'h0000);
    oe_ni = 1'b0; addr_i = 16'h0777; settle();
    chk("R10", "still async before capture", data_o, word_at(16'h0777));
    oe_ni = 1'b1;
    capture(16'h0100);
    oe_ni = 1'b0; addr_i = 16'h0000; settle();
    chk("R3", "first word", data_o, word_at(16'h0100));
    chk("R4", "addr ignored in burst", 32'(data_oe_o), 32'd1);
    burst_ni = 1'b0; tick();
    chk("R4", "step 1", data_o, word_at(16'h0101));
    tick();
    chk("R4", "step 2", data_o, word_at(16'h0102));
    oe_ni = 1'b1; burst_ni = 1'b1; settle();
    chk("R5", "suspend floats", 32'(data_oe_o), 32'd0);
    tick(); tick(); tick();
    oe_ni = 1'b0; settle();
    chk("R5", "resume same word", data_o, word_at(16'h0102));
    oe_ni = 1'b1; burst_ni = 1'b0; tick(); tick();
    oe_ni = 1'b0; burst_ni = 1'b1; settle();
    chk("R5", "oe high holds counter", data_o, word_at(16'h0102));
    burst_ni = 1'b0; tick();
    chk("R4", "step after resume", data_o, word_at(16'h0103));
    burst_ni = 1'b1;
  endtask

  task automatic t_midcfg();
    burst_ni = 1'b0;
    cfg_write(16'h8000);
    chk("R10", "burst steps after cfg write", data_o, word_at(16'h0104));
    tick();
    chk("R10", "burst keeps sync", data_o, word_at(16'h0105));
    burst_ni = 1'b1; oe_ni = 1'b1;
    capture(16'h0200);
    oe_ni = 1'b0; addr_i = 16'h0333; settle();
    chk("R10", "async after capture", data_o, word_at(16'h0333));
    oe_ni = 1'b1;
  endtask

  task automatic t_wrap();
    cfg_write(16'h0000);
    capture(16'hFFFF);
    oe_ni = 1'b0; settle();
    chk("R6", "last word", data_o, word_at(16'hFFFF));
    burst_ni = 1'b0; tick();
    chk("R6", "wrapped word", data_o, word_at(16'h0000));
    burst_ni = 1'b1; oe_ni = 1'b1;
  endtask

  task automatic t_abort_ce();
    capture(16'h0040);
    oe_ni = 1'b0; burst_ni = 1'b0; tick();
    chk("R4", "step before abort", data_o, word_at(16'h0041));
    ce_ni = 1'b1; settle();
    chk("R7", "ce high floats", 32'(data_oe_o), 32'd0);
    tick();
    ce_ni = 1'b0; burst_ni = 1'b1; settle();
    chk("R7", "no drive after abort", 32'(data_oe_o), 32'd0);
    burst_ni = 1'b0; tick();
    chk("R7", "advance does not revive", 32'(data_oe_o), 32'd0);
    burst_ni = 1'b1; oe_ni = 1'b1;
  endtask

  task automatic t_abort_rst();
    capture(16'h0050);
    oe_ni = 1'b0; settle();
    chk("R3", "burst before reset", data_o, word_at(16'h0050));
    rst_ni = 1'b0; settle();
    chk("R8", "reset floats", 32'(data_oe_o), 32'd0);
    chk("R8", "reset zero bus", data_o, 32'd0);
    tick(); rst_ni = 1'b1;
    addr_i = 16'h0060; settle();
    chk("R8", "async after reset", data_o, word_at(16'h0060));
    oe_ni = 1'b1; ce_ni = 1'b1;
  endtask

  task automatic t_standby();
    settle();
    chk("R9", "standby default", 32'(standby_o), 32'd1);
    cfg_write(16'h4000);
    chk("R9", "standby disabled", 32'(standby_o), 32'd0);
    cfg_write(16'h8000);
    chk("R9", "standby enabled again", 32'(standby_o), 32'd1);
    ce_ni = 1'b0; settle();
    chk("R9", "selected not standby", 32'(standby_o), 32'd0);
    ce_ni = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_async();
    t_burst();
    t_midcfg();
    t_wrap();
    t_abort_ce();
    t_abort_rst();
    t_standby();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end
endmodule